// File: doc/BRIEF.md
# Dead-Band PWM Channel

This block is one pulse-width-modulation channel meant to drive one half-bridge. A free-running 16-bit counter sets the period. It counts either downward with a wrap, or up and then down in a triangle. The counter flags the cycles in which it sits at zero or at the period value. Two compare registers flag the cycles in which the count equals them. Each of the two waveform generators keeps one output bit, and each event it sees can set, clear or toggle that bit. Compare events carry separate actions for the rising and the falling half of a triangle.

An optional edge-delay stage turns generator A into a complementary pair with a programmed gap before each turn-on. An output stage then applies an enable, a polarity flip and a fault shut-off to each pin. The period and the compare values can be written at any time. Writes can also be parked in a holding register and applied when the count next reaches zero, so a running period is never cut short.

Software drives everything through a simple write port: a 4-bit address, 16-bit data and a strobe. No value is read back. The count, its direction and the two counter events are brought out as ports so that they can be observed.

Top module: `pwm_deadband_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `pwm_hi`, `pwm_lo`, `zero_evt`, `load_evt`, `dir_up_o` and `cnt_o` are all 0. All registers clear to 0 (counter stopped).
- R2: With control bit 0 (run) set and bit 1 (triangle) clear, the count falls by one every clock. From 0 it reloads the active period value. With run clear, the count holds.
- R3: With run and triangle set, the count rises by one per clock until it reaches or passes the period value, then falls by one per clock to 0, then rises again. `dir_up_o` shows the direction of the step that produced the current count. A period of 0 keeps the count at 0.
- R4: `zero_evt` is high in each cycle where run is set and the count is 0. `load_evt` is high in each cycle where run is set and the count equals the active period. Both are low while run is clear. Compare events follow the same rule against the two active compare values.
- R5: An action register holds six 2-bit codes. Bits [1:0] are the zero action, [3:2] the period action, [5:4] compare-A on the way up, [7:6] compare-A on the way down, [9:8] compare-B up and [11:10] compare-B down. Code 00 keeps the bit, 01 toggles it, 10 clears it and 11 sets it. The generator bit changes at the clock edge that ends the event cycle. Generator A uses address 4 and generator B uses address 5.
- R6: When several events fall in one cycle, the single action applied is the first non-00 code in the order zero, period, compare-B, compare-A.
- R7: With control bit 2 set, a period write goes to a holding register and becomes active at the edge that ends a cycle with `zero_evt` high. Control bit 3 does the same for both compare values. With the bit clear, the write takes effect at the next edge.
- R8: With control bit 4 set, `pwm_hi` follows generator A but rises only after A has been high for the number of clocks in the rise register. `pwm_lo` follows the inverse of A but rises only after it has been high for the number of clocks in the fall register. Both fall at once.
- R9: With control bit 4 clear, `pwm_hi` carries generator A and `pwm_lo` carries generator B unchanged.
- R10: Output register bits 0 and 1 enable `pwm_hi` and `pwm_lo`; a disabled pin is 0. Bits 2 and 3 invert the high-side and low-side pins.
- R11: Output register bits 4 and 5 arm fault handling for the high and low side. In any cycle where `fault` is high, an armed pin is 0 in that same cycle.
- R12: The write addresses are: 0 control, 1 period, 2 compare-A, 3 compare-B, 4 and 5 actions, 6 rise delay, 7 fall delay, 8 output control. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| fault | input | 1 | Fault request, acts in the same cycle |
| pwm_hi | output | 1 | High-side pin |
| pwm_lo | output | 1 | Low-side pin |
| cnt_o | output | 16 | Current count |
| dir_up_o | output | 1 | Count direction (1 = rising) |
| zero_evt | output | 1 | Count-at-zero event |
| load_evt | output | 1 | Count-at-period event |

## Verification
Two things collide at the zero count. The parked period or compare copy lands at that edge, and the zero action and compare-at-zero actions fire at the same edge, sometimes together with a fresh write to the same register. The bench makes these meet on purpose. It puts compare values at 0 and at the period, and it writes while deferral is armed just as the count wraps. It then judges each cycle against a bench cycle model built from the requirement rules. That model settles which value is active and which single action wins. Random register writes and fault toggles then repeat the collisions under many other settings.

// File: rtl/pwmdb_pkg.sv
`timescale 1ns/1ps
package pwmdb_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_LOAD  = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMPA  = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMPB  = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_ACTA  = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_ACTB  = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_RISE  = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_FALL  = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_OUTC  = 4'd8;

    // per-event action on a generator bit
    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLR    = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    // field order is fixed by the action register layout (LSB = on_zero)
    typedef struct packed {
        act_e cmpb_dn;
        act_e cmpb_up;
        act_e cmpa_dn;
        act_e cmpa_up;
        act_e on_load;
        act_e on_zero;
    } act_set_t;

    typedef struct packed {
        logic db_en;
        logic defer_cmp;
        logic defer_load;
        logic updown;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic flt_lo;
        logic flt_hi;
        logic inv_lo;
        logic inv_hi;
        logic en_lo;
        logic en_hi;
    } outctl_t;

    typedef struct packed {
        logic zero;
        logic load;
        logic cmpa;
        logic cmpb;
        logic up;
    } evt_t;

    // lowest priority first, later non-keep codes override
    function automatic act_e pick_action(evt_t e, act_set_t s);
        act_e a;
        act_e c;
        a = ACT_KEEP;
        if (e.cmpa) begin
            c = e.up ? s.cmpa_up : s.cmpa_dn;
            if (c != ACT_KEEP) a = c;
        end
        if (e.cmpb) begin
            c = e.up ? s.cmpb_up : s.cmpb_dn;
            if (c != ACT_KEEP) a = c;
        end
        if (e.load && s.on_load != ACT_KEEP) a = s.on_load;
        if (e.zero && s.on_zero != ACT_KEEP) a = s.on_zero;
        return a;
    endfunction

    function automatic logic apply_action(act_e a, logic cur);
        logic r;
        case (a)
            ACT_TOGGLE: r = ~cur;
            ACT_CLR:    r = 1'b0;
            ACT_SET:    r = 1'b1;
            default:    r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmdb_counter.sv
`timescale 1ns/1ps
module pwmdb_counter
    import pwmdb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             updown,
    input  logic [CNT_W-1:0] load_v,
    input  logic [CNT_W-1:0] cmpa_v,
    input  logic [CNT_W-1:0] cmpb_v,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output evt_t             ev
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_nx;
    logic             dir_nx;

    always_comb begin
        ev.zero = run && (cnt == ZERO);
        ev.load = run && (cnt == load_v);
        ev.cmpa = run && (cnt == cmpa_v);
        ev.cmpb = run && (cnt == cmpb_v);
        ev.up   = dir_up;
    end

    always_comb begin
        cnt_nx = cnt;
        dir_nx = dir_up;
        if (run) begin
            if (!updown) begin
                dir_nx = 1'b0;
                cnt_nx = (cnt == ZERO) ? load_v : cnt - ONE;
            end else if (load_v == ZERO) begin
                cnt_nx = ZERO;
                dir_nx = 1'b1;
            end else if (dir_up) begin
                if (cnt >= load_v) begin
                    cnt_nx = cnt - ONE;
                    dir_nx = 1'b0;
                end else begin
                    cnt_nx = cnt + ONE;
                end
            end else begin
                if (cnt == ZERO) begin
                    cnt_nx = ONE;
                    dir_nx = 1'b1;
                end else begin
                    cnt_nx = cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= ZERO;
            dir_up <= 1'b0;
        end else begin
            cnt    <= cnt_nx;
            dir_up <= dir_nx;
        end
    end

    assert_down_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !updown && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> $stable(cnt));

    assert_valley_turn_R3: assert property (@(posedge clk) disable iff (rst)
        (run && updown && cnt == ZERO && load_v != ZERO) |=> (cnt == ONE && dir_up));

endmodule

// File: rtl/pwmdb_actgen.sv
`timescale 1ns/1ps
module pwmdb_actgen
    import pwmdb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_t     ev,
    input  act_set_t acts,
    output logic     pwm
);

    act_e sel;
    logic any_ev;

    always_comb begin
        sel    = pick_action(ev, acts);
        any_ev = ev.zero | ev.load | ev.cmpa | ev.cmpb;
    end

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= apply_action(sel, pwm);
    end

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!any_ev) |=> $stable(pwm));

endmodule

// File: rtl/pwmdb_deadband.sv
`timescale 1ns/1ps
module pwmdb_deadband #(
    parameter int DB_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sig_in,
    input  logic [DB_W-1:0] delay,
    output logic            sig_out
);

    logic [DB_W-1:0] high_len;

    always_ff @(posedge clk) begin
        if (rst)                 high_len <= '0;
        else if (!sig_in)        high_len <= '0;
        else if (high_len < delay) high_len <= high_len + DB_W'(1);
    end

    assign sig_out = sig_in && (high_len >= delay);

    assert_late_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (delay != '0 && $rose(sig_out)) |-> $past(sig_in));

endmodule

// File: rtl/pwm_deadband_gen.sv
`timescale 1ns/1ps
module pwm_deadband_gen
    import pwmdb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DB_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              fault,
    output logic              pwm_hi,
    output logic              pwm_lo,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_up_o,
    output logic              zero_evt,
    output logic              load_evt
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int ACT_W  = $bits(act_set_t);
    localparam int OC_W   = $bits(outctl_t);
    localparam int NGEN   = 2;

    ctrl_t            ctrl;
    outctl_t          oc;
    act_set_t         acts [NGEN];
    logic [DB_W-1:0]  db_delay [NGEN];
    logic [CNT_W-1:0] load_sh, load_act;
    logic [CNT_W-1:0] cmpa_sh, cmpa_act;
    logic [CNT_W-1:0] cmpb_sh, cmpb_act;

    evt_t             ev;
    logic [NGEN-1:0]  gen_out;
    logic [NGEN-1:0]  db_in, db_out, pre, pin;
    logic [NGEN-1:0]  en_v, inv_v, flt_v;

    // register file with zero-aligned shadow copy
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            oc       <= '0;
            acts[0]  <= '0;
            acts[1]  <= '0;
            db_delay[0] <= '0;
            db_delay[1] <= '0;
            load_sh  <= '0;
            load_act <= '0;
            cmpa_sh  <= '0;
            cmpa_act <= '0;
            cmpb_sh  <= '0;
            cmpb_act <= '0;
        end else begin
            if (ev.zero) begin
                load_act <= load_sh;
                cmpa_act <= cmpa_sh;
                cmpb_act <= cmpb_sh;
            end
            if (wr_en) begin
                case (wr_addr)
                    ADDR_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    ADDR_LOAD: begin
                        load_sh <= wr_data;
                        if (!ctrl.defer_load) load_act <= wr_data;
                    end
                    ADDR_CMPA: begin
                        cmpa_sh <= wr_data;
                        if (!ctrl.defer_cmp) cmpa_act <= wr_data;
                    end
                    ADDR_CMPB: begin
                        cmpb_sh <= wr_data;
                        if (!ctrl.defer_cmp) cmpb_act <= wr_data;
                    end
                    ADDR_ACTA: acts[0] <= act_set_t'(wr_data[ACT_W-1:0]);
                    ADDR_ACTB: acts[1] <= act_set_t'(wr_data[ACT_W-1:0]);
                    ADDR_RISE: db_delay[0] <= wr_data[DB_W-1:0];
                    ADDR_FALL: db_delay[1] <= wr_data[DB_W-1:0];
                    ADDR_OUTC: oc <= outctl_t'(wr_data[OC_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    pwmdb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.run),
        .updown (ctrl.updown),
        .load_v (load_act),
        .cmpa_v (cmpa_act),
        .cmpb_v (cmpb_act),
        .cnt    (cnt_o),
        .dir_up (dir_up_o),
        .ev     (ev)
    );

    assign zero_evt = ev.zero;
    assign load_evt = ev.load;

    // index 0 = high side / generator A, index 1 = low side / generator B
    assign db_in = {~gen_out[0], gen_out[0]};
    assign en_v  = {oc.en_lo,  oc.en_hi};
    assign inv_v = {oc.inv_lo, oc.inv_hi};
    assign flt_v = {oc.flt_lo, oc.flt_hi};

    for (genvar g = 0; g < NGEN; g++) begin : g_chan
        pwmdb_actgen u_gen (
            .clk  (clk),
            .rst  (rst),
            .ev   (ev),
            .acts (acts[g]),
            .pwm  (gen_out[g])
        );

        pwmdb_deadband #(.DB_W(DB_W)) u_db (
            .clk     (clk),
            .rst     (rst),
            .sig_in  (db_in[g]),
            .delay   (db_delay[g]),
            .sig_out (db_out[g])
        );

        assign pre[g] = ctrl.db_en ? db_out[g] : gen_out[g];
        assign pin[g] = en_v[g] & ~(fault & flt_v[g]) & (pre[g] ^ inv_v[g]);
    end

    assign pwm_hi = pin[0];
    assign pwm_lo = pin[1];

    assert_fault_kill_R11: assert property (@(posedge clk) disable iff (rst)
        (fault && oc.flt_hi) |-> !pwm_hi);

    assert_disabled_low_R10: assert property (@(posedge clk) disable iff (rst)
        (!oc.en_lo) |-> !pwm_lo);

    assert_defer_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.defer_load && !ev.zero && !(wr_en && wr_addr == ADDR_LOAD))
        |=> $stable(load_act));

    assert_pair_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.db_en && oc.en_hi && oc.en_lo && !oc.inv_hi && !oc.inv_lo)
        |-> !(pwm_hi && pwm_lo));

endmodule

// File: tb/tb_pwm_deadband_gen.sv
`timescale 1ns/1ps
module tb_pwm_deadband_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic        fault;
    logic        pwm_hi, pwm_lo, dir_up_o, zero_evt, load_evt;
    logic [15:0] cnt_o;

    int checks = 0;
    int errors = 0;
    string phase_req = "R1";

    always #4 clk = ~clk;

    pwm_deadband_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault(fault), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .cnt_o(cnt_o),
        .dir_up_o(dir_up_o), .zero_evt(zero_evt), .load_evt(load_evt)
    );

    // ---------------- reference cycle model ----------------
    logic [15:0] m_cnt, m_lsh, m_lact, m_ash, m_aact, m_bsh, m_bact;
    logic        m_dir, m_ga, m_gb;
    logic [4:0]  m_ctrl;
    logic [11:0] m_acta, m_actb;
    logic [9:0]  m_rise, m_fall, m_ch, m_cl;
    logic [5:0]  m_oc;

    function automatic logic [1:0] f_pick(logic z, logic l, logic a, logic b, logic up,
                                          logic [11:0] s);
        logic [1:0] r, c;
        r = 2'b00;
        if (a) begin c = up ? s[5:4] : s[7:6]; if (c != 0) r = c; end
        if (b) begin c = up ? s[9:8] : s[11:10]; if (c != 0) r = c; end
        if (l && s[3:2] != 0) r = s[3:2];
        if (z && s[1:0] != 0) r = s[1:0];
        return r;
    endfunction

    function automatic logic f_apply(logic [1:0] c, logic cur);
        case (c)
            2'b01: return ~cur;
            2'b10: return 1'b0;
            2'b11: return 1'b1;
            default: return cur;
        endcase
    endfunction

    always @(posedge clk) begin
        logic run, ud, ez, el, ea, eb, n_dir;
        logic [15:0] n_cnt, n_lact, n_aact, n_bact;
        if (rst) begin
            m_cnt = 0; m_lsh = 0; m_lact = 0; m_ash = 0; m_aact = 0; m_bsh = 0; m_bact = 0;
            m_dir = 0; m_ga = 0; m_gb = 0; m_ctrl = 0; m_acta = 0; m_actb = 0;
            m_rise = 0; m_fall = 0; m_ch = 0; m_cl = 0; m_oc = 0;
        end else begin
            run = m_ctrl[0]; ud = m_ctrl[1];
            ez = run && (m_cnt == 0);
            el = run && (m_cnt == m_lact);
            ea = run && (m_cnt == m_aact);
            eb = run && (m_cnt == m_bact);
            n_cnt = m_cnt; n_dir = m_dir;
            if (run) begin
                if (!ud) begin
                    n_dir = 0;
                    n_cnt = (m_cnt == 0) ? m_lact : m_cnt - 16'd1;
                end else if (m_lact == 0) begin
                    n_cnt = 0; n_dir = 1;
                end else if (m_dir) begin
                    if (m_cnt >= m_lact) begin n_cnt = m_cnt - 16'd1; n_dir = 0; end
                    else n_cnt = m_cnt + 16'd1;
                end else begin
                    if (m_cnt == 0) begin n_cnt = 16'd1; n_dir = 1; end
                    else n_cnt = m_cnt - 16'd1;
                end
            end
            // dead-band run lengths use the generator bit before its update
            if (!m_ga) m_ch = 0; else if (m_ch < m_rise) m_ch = m_ch + 10'd1;
            if (m_ga)  m_cl = 0; else if (m_cl < m_fall) m_cl = m_cl + 10'd1;
            m_ga = f_apply(f_pick(ez, el, ea, eb, m_dir, m_acta), m_ga);
            m_gb = f_apply(f_pick(ez, el, ea, eb, m_dir, m_actb), m_gb);
            n_lact = ez ? m_lsh : m_lact;
            n_aact = ez ? m_ash : m_aact;
            n_bact = ez ? m_bsh : m_bact;
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_ctrl = wr_data[4:0];
                    4'd1: begin m_lsh = wr_data; if (!m_ctrl[2]) n_lact = wr_data; end
                    4'd2: begin m_ash = wr_data; if (!m_ctrl[3]) n_aact = wr_data; end
                    4'd3: begin m_bsh = wr_data; if (!m_ctrl[3]) n_bact = wr_data; end
                    4'd4: m_acta = wr_data[11:0];
                    4'd5: m_actb = wr_data[11:0];
                    4'd6: m_rise = wr_data[9:0];
                    4'd7: m_fall = wr_data[9:0];
                    4'd8: m_oc = wr_data[5:0];
                    default: ;
                endcase
            end
            m_cnt = n_cnt; m_dir = n_dir;
            m_lact = n_lact; m_aact = n_aact; m_bact = n_bact;
        end
    end

    function automatic logic exp_hi();
        logic pre;
        pre = m_ctrl[4] ? (m_ga && m_ch >= m_rise) : m_ga;
        return m_oc[0] && !(fault && m_oc[4]) && (pre ^ m_oc[2]);
    endfunction

    function automatic logic exp_lo();
        logic pre;
        pre = m_ctrl[4] ? (!m_ga && m_cl >= m_fall) : m_gb;
        return m_oc[1] && !(fault && m_oc[5]) && (pre ^ m_oc[3]);
    endfunction

    // ---------------- checking ----------------
    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(m_ctrl[1] ? "R3" : "R2", "cnt", int'(cnt_o), int'(m_cnt));
        chk("R3", "dir", int'(dir_up_o), int'(m_dir));
        chk("R4", "zero_evt", int'(zero_evt), int'(m_ctrl[0] && m_cnt == 0));
        chk("R4", "load_evt", int'(load_evt), int'(m_ctrl[0] && m_cnt == m_lact));
        chk(phase_req, "pwm_hi", int'(pwm_hi), int'(exp_hi()));
        chk(phase_req, "pwm_lo", int'(pwm_lo), int'(exp_lo()));
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd7351);
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; fault = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk("R1", "reset pwm_hi", int'(pwm_hi), 0);
        chk("R1", "reset pwm_lo", int'(pwm_lo), 0);
        chk("R1", "reset cnt", int'(cnt_o), 0);
        chk("R1", "reset zero_evt", int'(zero_evt), 0);
        rst = 1'b0;
        tick();
        chk("R1", "post-reset load_evt", int'(load_evt), 0);

        // R12 / R2: map and wrap in down mode
        phase_req = "R5";
        wr(4'd8, 16'h0003);
        wr(4'd1, 16'd5);
        wr(4'd2, 16'd2);
        wr(4'd4, 16'b00_00_10_00_00_11);   // zero set, cmpA down clear
        wr(4'd5, 16'b00_00_00_00_01_00);   // period toggle
        wr(4'd0, 16'h0001);
        tick();
        chk("R12", "reload from period via address 1", int'(cnt_o), 5);
        wr(4'd9, 16'h001F);                // unmapped: ignored
        idle(30);

        // R3: triangle with directional compare actions
        phase_req = "R3";
        wr(4'd0, 16'h0003);
        wr(4'd4, 16'b00_00_10_11_00_00);   // cmpA up set, down clear
        wr(4'd2, 16'd3);
        idle(40);
        wr(4'd1, 16'd0);
        idle(6);
        wr(4'd1, 16'd6);
        idle(20);

        // R6: stacked events at zero and at period
        phase_req = "R6";
        wr(4'd0, 16'h0001);
        wr(4'd2, 16'd0);
        wr(4'd3, 16'd0);
        wr(4'd4, 16'b10_00_01_00_00_11);
        wr(4'd5, 16'b11_00_00_00_10_00);
        wr(4'd3, 16'd6);
        idle(40);

        // R7: parked writes applied at zero
        phase_req = "R7";
        wr(4'd0, 16'h000D);
        wr(4'd1, 16'd20);
        idle(3);
        wr(4'd2, 16'd9);
        idle(30);
        wr(4'd1, 16'd4);
        idle(40);
        wr(4'd0, 16'h0001);

        // R8 / R9: dead-band on, then bypassed
        phase_req = "R8";
        wr(4'd1, 16'd15);
        wr(4'd2, 16'd7);
        wr(4'd4, 16'b00_00_10_00_00_11);
        wr(4'd6, 16'd3);
        wr(4'd7, 16'd5);
        wr(4'd0, 16'h0011);
        idle(80);
        wr(4'd6, 16'd0);
        idle(40);
        phase_req = "R9";
        wr(4'd0, 16'h0001);
        idle(40);

        // R10: every enable/invert combination
        phase_req = "R10";
        for (int k = 0; k < 16; k++) begin
            wr(4'd8, 16'(k));
            idle(12);
        end

        // R11: fault on one armed side only
        phase_req = "R11";
        wr(4'd8, 16'h0013);
        fault = 1'b1; idle(20);
        fault = 1'b0; idle(10);
        wr(4'd8, 16'h003F);
        fault = 1'b1; idle(20);
        fault = 1'b0;

        // random mix
        phase_req = "R5";
        for (int it = 0; it < 400; it++) begin
            int unsigned a;
            logic [15:0] d;
            a = $urandom_range(0, 9);
            case (a)
                0: d = 16'($urandom_range(0, 31) | (($urandom_range(0, 4) != 0) ? 1 : 0));
                1: d = 16'($urandom_range(0, 40));
                2, 3: d = 16'($urandom_range(0, 42));
                4, 5: d = 16'($urandom_range(0, 4095));
                6, 7: d = 16'($urandom_range(0, 6));
                8: d = 16'($urandom_range(0, 63));
                default: d = 16'hFFFF;
            endcase
            if ($urandom_range(0, 5) == 0) fault = ~fault;
            wr(4'(a), d);
            idle(int'($urandom_range(0, 15)));
        end
        fault = 1'b0;
        idle(5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule